// File: doc/BRIEF.md
# Mask-Driven Bit Pattern Generator

This unit builds the trailing-bit style masks used by predicated vector code: clear the lowest set bit, isolate it, form a mask up to or below it, fill trailing zeros, and so on. It applies a mask operand to a source operand. A five-bit mode word then picks three things: an arithmetic transform of the masked value, an optional inversion of the masked value, and a bitwise combiner that joins the two. Every result is therefore one expression of the form combine(invert?(x), transform(x)). That expression covers 24 separate operations.

A half-width flag limits the operation to the low half of the word. The result is always limited to the bits the mask operand enables. The result is captured in an output register, and a valid flag marks it one cycle after the input strobe. Instruction decode, register reads and loop predication belong to the surrounding pipeline.

Top module: `mask_bitgen`

## Requirements
- R1: `out_vld` is high in the cycle after an edge at which `in_vld` was high, and low in the cycle after an edge at which `in_vld` was low.
- R2: While the reset is active, and until the first accepted input, `out_vld` and `out_res` are zero.
- R3: `in_mode[1:0]` selects the transform T of x: 00 gives x+1, 01 gives x-1, 10 gives ~(x+1), 11 gives -x. The arithmetic is modulo 2^DATA_W.
- R4: `in_mode[3:2]` selects the combiner of A and T: 00 gives OR, 01 gives AND, 10 gives XOR. The code 11 is reserved and yields an all-zero result.
- R5: `in_mode[4]` selects A: 0 gives x and 1 gives ~x.
- R6: x is `in_src & in_msk`. Source bits where the mask is zero have no effect on the result.
- R7: Every result bit where `in_msk` is zero reads as zero.
- R8: When `in_half` is 1, the source bits in the upper half have no effect, and the upper half of the result is zero.
- R9: When `in_vld` is low, `out_res` holds its last value whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input strobe; captures a new result |
| in_src | input | DATA_W | Source operand |
| in_msk | input | DATA_W | Mask operand |
| in_mode | input | 5 | Bits 1:0 transform, bits 3:2 combiner, bit 4 inversion |
| in_half | input | 1 | Operate on the low half only |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_res | output | DATA_W | Registered result |

## Verification
The datapath is combinational up to a single output register, so any wrong internal value appears on `out_res` in the very next cycle after the strobe. A fault in the transform, the inversion or the combiner select shows as a miscompare for the modes that use that path. The bench sweeps all 32 mode codes over several operands, so each fault is hit by several modes. A fault in the enable or valid register shows as an unexpected valid, a missing valid or a result that drifts while idle. The bench checks for these in the cycle they would happen.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  typedef enum logic [1:0] {
    XF_INC  = 2'b00,
    XF_DEC  = 2'b01,
    XF_NINC = 2'b10,
    XF_NEG  = 2'b11
  } xform_e;

  typedef enum logic [1:0] {
    CMB_OR   = 2'b00,
    CMB_AND  = 2'b01,
    CMB_XOR  = 2'b10,
    CMB_RSVD = 2'b11
  } comb_e;

  // 5-bit mode word: [4] invert, [3:2] combiner, [1:0] transform
  typedef struct packed {
    logic   inv_a;
    comb_e  comb;
    xform_e xf;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);

endpackage

// File: rtl/mbm_rst_sync.sv
module mbm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mbm_operand_prep.sv
module mbm_operand_prep #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] msk,
  input  logic              half,
  output logic [DATA_W-1:0] keep,
  output logic [DATA_W-1:0] x
);

  localparam int unsigned LO_W = DATA_W / 2;
  localparam int unsigned HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] lane;

  // Upper lane is enabled only in full-width operation
  always_comb begin
    lane = {{HI_W{~half}}, {LO_W{1'b1}}};
    keep = msk & lane;
    x    = src & keep;
  end

endmodule

// File: rtl/mbm_xform.sv
module mbm_xform
  import mbm_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] x,
  input  xform_e            xf,
  output logic [DATA_W-1:0] t
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] inc;
  logic [DATA_W-1:0] dec;

  always_comb begin
    inc = x + ONE;
    dec = x - ONE;
    unique case (xf)
      XF_INC:  t = inc;
      XF_DEC:  t = dec;
      XF_NINC: t = ~inc;
      XF_NEG:  t = ~dec;   // two's complement negate: -x == ~(x-1)
      default: t = '0;
    endcase
  end

endmodule

// File: rtl/mbm_combine.sv
module mbm_combine
  import mbm_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] t,
  input  logic [DATA_W-1:0] keep,
  input  logic              inv_a,
  input  comb_e             comb,
  output logic [DATA_W-1:0] r
);

  logic [DATA_W-1:0] a;
  logic [DATA_W-1:0] joined;

  always_comb begin
    a = inv_a ? ~x : x;
    unique case (comb)
      CMB_OR:   joined = a | t;
      CMB_AND:  joined = a & t;
      CMB_XOR:  joined = a ^ t;
      CMB_RSVD: joined = '0;
      default:  joined = '0;
    endcase
    r = joined & keep;
  end

endmodule

// File: rtl/mask_bitgen.sv
module mask_bitgen
  import mbm_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_msk,
  input  logic [4:0]        in_mode,
  input  logic              in_half,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_res
);

  logic              rst_sync_n;
  mode_t             mode_s;
  logic [DATA_W-1:0] keep_s;
  logic [DATA_W-1:0] x_s;
  logic [DATA_W-1:0] t_s;
  logic [DATA_W-1:0] r_s;

  logic              vld_d, vld_q;
  logic [DATA_W-1:0] res_d, res_q;

  assign mode_s = mode_t'(in_mode);

  mbm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mbm_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .src  (in_src),
    .msk  (in_msk),
    .half (in_half),
    .keep (keep_s),
    .x    (x_s)
  );

  mbm_xform #(.DATA_W(DATA_W)) u_xform (
    .x  (x_s),
    .xf (mode_s.xf),
    .t  (t_s)
  );

  mbm_combine #(.DATA_W(DATA_W)) u_comb (
    .x     (x_s),
    .t     (t_s),
    .keep  (keep_s),
    .inv_a (mode_s.inv_a),
    .comb  (mode_s.comb),
    .r     (r_s)
  );

  // Next state: result register enabled by the input strobe
  always_comb begin
    vld_d = in_vld;
    res_d = in_vld ? r_s : res_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_vld = vld_q;
  assign out_res = res_q;

endmodule

// File: rtl/mask_bitgen_chk.sv
module mask_bitgen_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [DATA_W-1:0] in_msk,
  input logic [4:0]        in_mode,
  input logic              in_half,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_res
);

  localparam int unsigned LO_W = DATA_W / 2;

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R1
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_res));

  // R7
  mask_confine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ((out_res & ~$past(in_msk)) == '0));

  // R8
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_half) |=> (out_res[DATA_W-1:LO_W] == '0));

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mode[3:2] == 2'b11) |=> (out_res == '0));

endmodule

bind mask_bitgen mask_bitgen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .in_vld  (in_vld),
  .in_msk  (in_msk),
  .in_mode (in_mode),
  .in_half (in_half),
  .out_vld (out_vld),
  .out_res (out_res)
);

// File: tb/mask_bitgen_bench.sv
`timescale 1ns/1ps
module mask_bitgen_bench;

  localparam int unsigned DATA_W = 64;

  logic              clk;
  logic              rst_n;
  logic              in_vld;
  logic [DATA_W-1:0] in_src;
  logic [DATA_W-1:0] in_msk;
  logic [4:0]        in_mode;
  logic              in_half;
  logic              out_vld;
  logic [DATA_W-1:0] out_res;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } item_t;

  item_t             sb_q[$];
  int                n_chk;
  int                n_bad;
  bit                done;
  logic [DATA_W-1:0] last_exp;

  mask_bitgen #(.DATA_W(DATA_W)) u_mask_bitgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_src  (in_src),
    .in_msk  (in_msk),
    .in_mode (in_mode),
    .in_half (in_half),
    .out_vld (out_vld),
    .out_res (out_res)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // Reference model written from the requirements
  function automatic logic [DATA_W-1:0] model(input logic [DATA_W-1:0] s,
                                              input logic [DATA_W-1:0] m,
                                              input logic [4:0] md,
                                              input logic h);
    logic [DATA_W-1:0] en, xv, tv, av, rv;
    en = m;
    if (h) en[DATA_W-1:DATA_W/2] = '0;                 // R8
    xv = s & en;                                       // R6
    case (md[1:0])                                     // R3
      2'b00: tv = xv + 1;
      2'b01: tv = xv - 1;
      2'b10: tv = ~(xv + 1);
      default: tv = -xv;
    endcase
    av = md[4] ? ~xv : xv;                             // R5
    case (md[3:2])                                     // R4
      2'b00: rv = av | tv;
      2'b01: rv = av & tv;
      2'b10: rv = av ^ tv;
      default: rv = '0;
    endcase
    return rv & en;                                    // R7
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [DATA_W-1:0] s, input logic [DATA_W-1:0] m,
                       input logic [4:0] md, input logic h,
                       input logic [DATA_W-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    in_vld  = 1'b1;
    in_src  = s;
    in_msk  = m;
    in_mode = md;
    in_half = h;
    it.exp  = exp;
    it.tag  = tag;
    sb_q.push_back(it);
    last_exp = exp;
  endtask

  task automatic drive_m(input logic [DATA_W-1:0] s, input logic [DATA_W-1:0] m,
                         input logic [4:0] md, input logic h, input string tag);
    drive(s, m, md, h, model(s, m, md, h), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld  = 1'b0;
      in_src  = {$urandom, $urandom};
      in_msk  = {$urandom, $urandom};
      in_mode = 5'($urandom);
      in_half = 1'($urandom);
    end
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        if (sb_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R1: out_vld=1 expected 0 (no pending item), res %h", out_res);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          check(it.tag, out_res, it.exp);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [DATA_W-1:0] ONES = '1;

  initial begin
    logic [DATA_W-1:0] ops [4];
    logic [DATA_W-1:0] msks[2];
    n_chk = 0; n_bad = 0; done = 1'b0; last_exp = '0;
    rst_n = 1'b0; in_vld = 1'b0; in_src = '0; in_msk = '0;
    in_mode = '0; in_half = 1'b0;
    repeat (3) @(negedge clk);
    // R2: outputs zero while reset is active
    check("R2 vld in reset", {63'd0, out_vld}, '0);
    check("R2 res in reset", out_res, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 vld after release", {63'd0, out_vld}, '0);
    check("R2 res after release", out_res, '0);

    // Directed patterns with known answers
    drive(64'h58, ONES, 5'b00101, 1'b0, 64'h50, "R3 R4 clear lowest set bit");
    drive(64'h58, ONES, 5'b01001, 1'b0, 64'h0F, "R4 xor with x-1");
    drive(64'h58, ONES, 5'b00111, 1'b0, 64'h08, "R3 isolate lowest set bit");
    drive(64'h57, ONES, 5'b01000, 1'b0, 64'h0F, "R3 xor with x+1");
    drive(64'h58, ONES, 5'b10101, 1'b0, 64'h07, "R5 trailing zero mask");
    drive(64'h58, ONES, 5'b00001, 1'b0, 64'h5F, "R4 or with x-1");
    drive(64'h58, ONES, 5'b01100, 1'b0, 64'h0,  "R4 reserved combiner");
    drive(64'h8000_0000_0000_0000, ONES, 5'b00111, 1'b0,
          64'h8000_0000_0000_0000, "R3 negate at top bit");
    drive(ONES, 64'hF0, 5'b00101, 1'b0, 64'hE0, "R6 masked source");
    drive(ONES, 64'hF0, 5'b10000, 1'b0, 64'hF0, "R7 result confined to mask");
    drive(ONES, ONES, 5'b00000, 1'b1, 64'h0000_0000_FFFF_FFFF, "R8 half carry dropped");
    drive(64'hABCD_0000_0000_0010, ONES, 5'b10010, 1'b1,
          64'h0000_0000_FFFF_FFEF, "R8 half upper source ignored");

    // Sweep of every mode code with and without the half flag
    ops[0] = '0; ops[1] = ONES; ops[2] = 64'h0000_0001_0000_0000;
    ops[3] = 64'h8000_00F0_0123_4500;
    msks[0] = ONES; msks[1] = 64'hFFFF_0000_FF00_FF0F;
    for (int o = 0; o < 4; o++)
      for (int k = 0; k < 2; k++)
        for (int md = 0; md < 32; md++)
          for (int h = 0; h < 2; h++)
            drive_m(ops[o], msks[k], 5'(md), 1'(h), "R3 R4 R5 R6 R7 R8 sweep");

    // R9: idle with changing inputs leaves the result unchanged
    drive(64'h58, ONES, 5'b00111, 1'b0, 64'h08, "R3 before hold");
    idle(5);
    check("R9 hold while idle", out_res, last_exp);
    check("R1 valid low while idle", {63'd0, out_vld}, '0);

    // R1: every pushed item was consumed
    n_chk++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: %0d results missing, expected 0", sb_q.size());
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule